// File: doc/BRIEF.md
# Switch-on-Miss Thread Scheduler

This block picks which hardware thread an in-order pipeline runs. Each thread is active, waiting in a FIFO ready queue, suspended, or idle. In switch-on-miss mode only one thread runs at a time. A thread asking to start while another runs waits in the queue. When the pipeline reports a cache miss for the running thread, that thread is taken off the active set and marked suspended. On the next clock, the oldest queued thread is started.

In simultaneous mode, and in single-thread mode (forced when only one thread is built), activate requests add threads straight to the active set. Each time a thread is brought into service, the block sends a one-cycle broadcast with its ID to the pipeline resources. A gate suppresses that broadcast where switch-on-miss operation would be wrong. A wake input brings back a suspended thread through the same rules as a fresh activate request. All outputs are registered and change on the clock edge that takes the request.

Top module: `som_thread_sched`

## Requirements
- R1: After synchronous active-high reset, no thread is active, suspended or queued, `activeValid` is 0, and `bcastValid` and `idle` are 0.
- R2: Outside switch-on-miss mode (`modeSom`=0, or only one thread built), an activate request for an inactive thread adds its bit to `activeMask` and pulses `bcastValid` with `bcastId` equal to that ID, both visible after the accepting edge.
- R3: In switch-on-miss mode with exactly one thread active, an activate request for another thread does not change `activeMask`. It raises no broadcast and appends the ID to the tail of the ready queue.
- R4: A miss report (`missReq`, `missId`) for an active thread clears its `activeMask` bit, sets its `suspMask` bit and raises no broadcast, all on the same edge. A miss report for an inactive thread is ignored.
- R5: Exactly one cycle after a miss is taken, the head of the ready queue is removed and made active, never on the same edge as the suspension. Queued threads start in the order they were queued. Requests presented in that promotion cycle are dropped.
- R6: If the ready queue is empty at the promotion step, no thread is activated, the state is unchanged, and `idle` is high for exactly one cycle.
- R7: `bcastValid` pulses only when the mode is not switch-on-miss, when no thread is active, or when the thread being activated is the current active thread. An activate request for the running thread rebroadcasts its ID and leaves the state unchanged.
- R8: An activate request for a thread that is already queued is ignored, so no ID is ever queued twice.
- R9: A wake request (`wakeReq`, `wakeId`) for a suspended thread clears its `suspMask` bit and is handled as an activate request. A wake request for a thread that is not suspended is ignored.
- R10: `activeId` is `{1'b0, id}` of the lowest-numbered active thread, which in switch-on-miss mode is the single running thread. It is all ones when no thread is active.
- R11: Within one cycle, a taken miss outranks an activate request, which outranks a wake request. The lower-ranked requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| modeSom | input | 1 | 1 = switch-on-miss, 0 = simultaneous |
| actReq | input | 1 | Activate request strobe |
| actId | input | TID_W | Thread to activate |
| missReq | input | 1 | Cache-miss report strobe |
| missId | input | TID_W | Thread that missed |
| wakeReq | input | 1 | Resume request strobe |
| wakeId | input | TID_W | Thread to resume |
| activeId | output | TID_W+1 | Current active thread, all ones when none |
| activeValid | output | 1 | At least one thread active |
| activeMask | output | NUM_THREADS | Active set, one bit per thread |
| suspMask | output | NUM_THREADS | Suspended set, one bit per thread |
| bcastValid | output | 1 | One-cycle activation broadcast |
| bcastId | output | TID_W | Thread named by the broadcast |
| idle | output | 1 | Promotion found the ready queue empty |

## Verification
Switch-on-miss operation is driven with a running thread plus several queued requests, then a chain of misses. This shows whether promotion order follows queue order and whether promotion lags the suspension by one cycle. Requests for an already-queued thread, for the running thread, and for an inactive missing thread separate the ignore, rebroadcast and drop paths. Wake requests are tried on suspended and non-suspended threads. A miss and an activate in the same cycle confirm that the activate is lost. A simultaneous-mode run shows direct activation, lowest-ID selection and the idle pulse with an empty queue.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Strobes from the control to the thread-state datapath for one cycle.
  typedef struct packed {
    logic setActive;
    logic clrActive;
    logic setSusp;
    logic clrSusp;
    logic push;
    logic pop;
    logic bcast;
    logic idle;
  } strobe_t;
endpackage

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   modeSom,
  input  logic                   actReq,
  input  logic [TID_W-1:0]       actId,
  input  logic                   missReq,
  input  logic [TID_W-1:0]       missId,
  input  logic                   wakeReq,
  input  logic [TID_W-1:0]       wakeId,
  input  logic [NUM_THREADS-1:0] activeMask,
  input  logic [NUM_THREADS-1:0] suspMask,
  input  logic [NUM_THREADS-1:0] queuedMask,
  input  logic                   qEmpty,
  input  logic [TID_W-1:0]       headId,
  input  logic [TID_W-1:0]       curId,
  input  logic                   curValid,
  output strobe_t                stb,
  output logic [TID_W-1:0]       stbId
);
  localparam int SLOTS = 1 << TID_W;

  logic [SLOTS-1:0] actPad, suspPad, queuePad, validPad;
  logic promotePending, promoteNext;
  logic missHit, reqHit;
  logic [TID_W-1:0] reqId;
  int activeCount;

  assign actPad   = SLOTS'(activeMask);
  assign suspPad  = SLOTS'(suspMask);
  assign queuePad = SLOTS'(queuedMask);
  assign validPad = SLOTS'({NUM_THREADS{1'b1}});
  assign activeCount = $countones(activeMask);

  function automatic logic bcastGate(input logic som, input int cnt,
                                     input logic cv, input logic [TID_W-1:0] cid,
                                     input logic [TID_W-1:0] id);
    return !som || (cnt == 0) || (cv && (cid == id));
  endfunction

  always_comb begin
    missHit = missReq && actPad[missId];
    reqHit  = 1'b0;
    reqId   = actId;
    if (actReq && validPad[actId]) begin
      reqHit = 1'b1;
      reqId  = actId;
    end else if (wakeReq && suspPad[wakeId]) begin
      reqHit = 1'b1;
      reqId  = wakeId;
    end
  end

  always_comb begin
    stb = '0;
    stbId = '0;
    promoteNext = 1'b0;
    if (promotePending) begin
      if (!qEmpty) begin
        stb.pop = 1'b1;
        stb.setActive = 1'b1;
        stbId = headId;
        stb.bcast = bcastGate(modeSom, activeCount, curValid, curId, headId);
      end else begin
        stb.idle = 1'b1;
      end
    end else if (missHit) begin
      stb.clrActive = 1'b1;
      stb.setSusp = 1'b1;
      stbId = missId;
      promoteNext = 1'b1;
    end else if (reqHit) begin
      stbId = reqId;
      if (actPad[reqId]) begin
        stb.bcast = bcastGate(modeSom, activeCount, curValid, curId, reqId);
      end else if (!queuePad[reqId]) begin
        stb.clrSusp = 1'b1;
        if (modeSom && activeCount == 1) begin
          stb.push = 1'b1;
        end else begin
          stb.setActive = 1'b1;
          stb.bcast = bcastGate(modeSom, activeCount, curValid, curId, reqId);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) promotePending <= 1'b0;
    else     promotePending <= promoteNext;
  end

  AST_PROMOTE_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
    stb.pop |-> $past(stb.clrActive && stb.setSusp)); // R5
  AST_IDLE_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
    stb.idle |-> $past(stb.clrActive)); // R6
  AST_MISS_NO_BCAST: assert property (@(posedge clk) disable iff (rst)
    stb.clrActive |-> !stb.bcast && !stb.setActive); // R4
endmodule

// File: rtl/sched_state.sv
module sched_state
  import sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int TID_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  strobe_t                stb,
  input  logic [TID_W-1:0]       stbId,
  output logic [NUM_THREADS-1:0] activeMask,
  output logic [NUM_THREADS-1:0] suspMask,
  output logic [NUM_THREADS-1:0] queuedMask,
  output logic                   qEmpty,
  output logic [TID_W-1:0]       headId,
  output logic [TID_W-1:0]       curId,
  output logic                   curValid,
  output logic                   bcastValid,
  output logic [TID_W-1:0]       bcastId,
  output logic                   idlePulse
);
  localparam int CNT_W = $clog2(NUM_THREADS + 1);

  logic [TID_W-1:0] queueMem [NUM_THREADS];
  logic [TID_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] qCount;

  function automatic logic [TID_W-1:0] bump(input logic [TID_W-1:0] p);
    return (p == TID_W'(NUM_THREADS - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < NUM_THREADS; g++) begin : gThread
    always_ff @(posedge clk) begin
      if (rst) begin
        activeMask[g] <= 1'b0;
        suspMask[g]   <= 1'b0;
        queuedMask[g] <= 1'b0;
      end else if (stbId == TID_W'(g)) begin
        if (stb.setActive)      activeMask[g] <= 1'b1;
        else if (stb.clrActive) activeMask[g] <= 1'b0;
        if (stb.setSusp)        suspMask[g] <= 1'b1;
        else if (stb.clrSusp)   suspMask[g] <= 1'b0;
        if (stb.push)           queuedMask[g] <= 1'b1;
        else if (stb.pop)       queuedMask[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
    end else begin
      if (stb.push) begin
        queueMem[wrPtr] <= stbId;
        wrPtr  <= bump(wrPtr);
        qCount <= qCount + 1'b1;
      end else if (stb.pop && qCount != 0) begin
        rdPtr  <= bump(rdPtr);
        qCount <= qCount - 1'b1;
      end
    end
  end

  assign qEmpty = (qCount == 0);
  assign headId = queueMem[rdPtr];

  always_comb begin
    curId = '0;
    for (int i = NUM_THREADS - 1; i >= 0; i--) begin
      if (activeMask[i]) curId = TID_W'(i);
    end
  end
  assign curValid = |activeMask;

  always_ff @(posedge clk) begin
    if (rst) begin
      bcastValid <= 1'b0;
      bcastId    <= '0;
      idlePulse  <= 1'b0;
    end else begin
      bcastValid <= stb.bcast;
      bcastId    <= stbId;
      idlePulse  <= stb.idle;
    end
  end

  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (rst)
    (queuedMask & activeMask) == '0); // R8
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (rst)
    qCount == CNT_W'($countones(queuedMask))); // R8
  AST_SUSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    (suspMask & activeMask) == '0); // R4
  AST_IDLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    idlePulse |=> !idlePulse); // R6
  AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    idlePulse |-> $stable(activeMask)); // R6
endmodule

// File: rtl/som_thread_sched.sv
module som_thread_sched
  import sched_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int ID_W = TID_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   modeSom,
  input  logic                   actReq,
  input  logic [TID_W-1:0]       actId,
  input  logic                   missReq,
  input  logic [TID_W-1:0]       missId,
  input  logic                   wakeReq,
  input  logic [TID_W-1:0]       wakeId,
  output logic [ID_W-1:0]        activeId,
  output logic                   activeValid,
  output logic [NUM_THREADS-1:0] activeMask,
  output logic [NUM_THREADS-1:0] suspMask,
  output logic                   bcastValid,
  output logic [TID_W-1:0]       bcastId,
  output logic                   idle
);
  localparam logic MULTI = (NUM_THREADS > 1);

  strobe_t stb;
  logic [TID_W-1:0] stbId, headId, curId;
  logic [NUM_THREADS-1:0] queuedMask;
  logic qEmpty, curValid, modeEff;

  assign modeEff = MULTI && modeSom;

  sched_ctrl #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) uCtrl (
    .clk(clk), .rst(rst), .modeSom(modeEff),
    .actReq(actReq), .actId(actId),
    .missReq(missReq), .missId(missId),
    .wakeReq(wakeReq), .wakeId(wakeId),
    .activeMask(activeMask), .suspMask(suspMask), .queuedMask(queuedMask),
    .qEmpty(qEmpty), .headId(headId), .curId(curId), .curValid(curValid),
    .stb(stb), .stbId(stbId)
  );

  sched_state #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) uState (
    .clk(clk), .rst(rst), .stb(stb), .stbId(stbId),
    .activeMask(activeMask), .suspMask(suspMask), .queuedMask(queuedMask),
    .qEmpty(qEmpty), .headId(headId), .curId(curId), .curValid(curValid),
    .bcastValid(bcastValid), .bcastId(bcastId), .idlePulse(idle)
  );

  assign activeValid = curValid;
  assign activeId = curValid ? {1'b0, curId} : '1;

  AST_INVALID_WHEN_NONE: assert property (@(posedge clk) disable iff (rst)
    !activeValid |-> (activeId == '1)); // R10
  AST_SOM_SINGLE_BCAST: assert property (@(posedge clk) disable iff (rst)
    (bcastValid && modeEff && $past(modeEff)) |-> activeValid && (activeMask[bcastId])); // R7
endmodule

// File: tb/som_thread_sched_test.sv
module som_thread_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic modeSom = 1'b1;
  logic actReq = 1'b0, missReq = 1'b0, wakeReq = 1'b0;
  logic [1:0] actId = '0, missId = '0, wakeId = '0;
  logic [2:0] activeId;
  logic activeValid, bcastValid, idle;
  logic [NT-1:0] activeMask, suspMask;
  logic [1:0] bcastId;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  som_thread_sched #(.NUM_THREADS(NT)) uut (
    .clk(clk), .rst(rst), .modeSom(modeSom),
    .actReq(actReq), .actId(actId), .missReq(missReq), .missId(missId),
    .wakeReq(wakeReq), .wakeId(wakeId),
    .activeId(activeId), .activeValid(activeValid), .activeMask(activeMask),
    .suspMask(suspMask), .bcastValid(bcastValid), .bcastId(bcastId), .idle(idle)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic som);
    rst = 1'b1;
    modeSom = som;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic activate(input int id);
    actReq = 1'b1; actId = 2'(id);
    tick();
    actReq = 1'b0;
  endtask

  task automatic miss(input int id);
    missReq = 1'b1; missId = 2'(id);
    tick();
    missReq = 1'b0;
  endtask

  task automatic wake(input int id);
    wakeReq = 1'b1; wakeId = 2'(id);
    tick();
    wakeReq = 1'b0;
  endtask

  task automatic testReset();
    doReset(1'b1);
    chk("R1", "activeValid", activeValid, 0);
    chk("R1", "activeMask", activeMask, 0);
    chk("R1", "suspMask", suspMask, 0);
    chk("R1", "bcastValid", bcastValid, 0);
    chk("R1", "idle", idle, 0);
    chk("R10", "activeId none", activeId, 7);
  endtask

  task automatic testSomQueue();
    activate(2);
    chk("R7", "bcast first start", bcastValid, 1);
    chk("R7", "bcastId first start", bcastId, 2);
    chk("R10", "activeId", activeId, 2);
    activate(0);
    chk("R3", "mask unchanged", activeMask, 4);
    chk("R3", "no bcast on queue", bcastValid, 0);
    activate(3);
    chk("R3", "mask unchanged 2", activeMask, 4);
    activate(0);
    chk("R8", "dup no bcast", bcastValid, 0);
    activate(2);
    chk("R7", "rebroadcast running", bcastValid, 1);
    chk("R7", "rebroadcast id", bcastId, 2);
    chk("R7", "state unchanged", activeMask, 4);
    miss(1);
    chk("R4", "miss inactive ignored", activeMask, 4);
    chk("R4", "miss inactive no susp", suspMask, 0);
    tick();
    chk("R4", "no promotion after ignored miss", idle, 0);
  endtask

  task automatic testSomPromote();
    miss(2);
    chk("R4", "active cleared", activeMask, 0);
    chk("R4", "suspended", suspMask, 4);
    chk("R4", "no bcast at suspend", bcastValid, 0);
    chk("R10", "activeId invalid", activeId, 7);
    tick();
    chk("R5", "head promoted", activeMask, 1);
    chk("R5", "bcast promote", bcastValid, 1);
    chk("R5", "bcastId promote", bcastId, 0);
    chk("R10", "activeId promoted", activeId, 0);
    miss(0);
    chk("R4", "suspended 2", suspMask, 5);
    tick();
    chk("R5", "second in order", activeMask, 8);
    chk("R5", "bcastId second", bcastId, 3);
    miss(3);
    tick();
    chk("R6", "idle empty queue", idle, 1);
    chk("R8", "no duplicate promoted", activeMask, 0);
    chk("R6", "susp unchanged", suspMask, 13);
    tick();
    chk("R6", "idle one cycle", idle, 0);
  endtask

  task automatic testWakePriority();
    wake(1);
    chk("R9", "wake non-suspended ignored", activeMask, 0);
    chk("R9", "wake no bcast", bcastValid, 0);
    wake(2);
    chk("R9", "wake starts", activeMask, 4);
    chk("R9", "wake clears susp", suspMask, 9);
    chk("R9", "wake bcast", bcastValid, 1);
    wake(0);
    chk("R9", "wake queued", activeMask, 4);
    chk("R9", "wake queued clears susp", suspMask, 8);
    missReq = 1'b1; missId = 2'd2;
    actReq = 1'b1; actId = 2'd1;
    tick();
    missReq = 1'b0; actReq = 1'b0;
    chk("R11", "miss wins", activeMask, 0);
    chk("R11", "miss suspends", suspMask, 12);
    tick();
    chk("R5", "woken thread promoted", activeMask, 1);
    miss(0);
    tick();
    chk("R11", "dropped activate not queued", idle, 1);
    chk("R11", "nothing active", activeMask, 0);
  endtask

  task automatic testSimultaneous();
    doReset(1'b0);
    activate(1);
    chk("R2", "direct add", activeMask, 2);
    chk("R2", "bcast", bcastValid, 1);
    chk("R2", "bcastId", bcastId, 1);
    activate(3);
    chk("R2", "second direct add", activeMask, 10);
    chk("R2", "bcastId 2", bcastId, 3);
    chk("R10", "lowest active id", activeId, 1);
    miss(1);
    chk("R4", "smt suspend", suspMask, 2);
    chk("R10", "lowest after miss", activeId, 3);
    tick();
    chk("R6", "smt idle empty", idle, 1);
    chk("R6", "smt state kept", activeMask, 8);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSomQueue();
    testSomPromote();
    testWakePriority();
    testSimultaneous();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule